// File: doc/BRIEF.md
# Delay-Line Sampling Phase Tuner

This block picks the receive sampling phase of a programmable delay line that sits in front of a high-speed card interface's data sampler. It works in two stages. First it calibrates the delay unit. It steps the 7-bit unit setting upward from zero, lets the line measure its own length, and stops at the first setting whose measured length fits inside the tap chain. The position of the highest set bit of that length becomes the largest usable phase.

In the second stage it walks every phase from zero to that limit. For each phase it asks an external tuning-test port whether a tuning block was received correctly. It keeps the longest unbroken run of passing phases and finally programs the phase in the middle of that run. The result stays on a registered output until the next start.

A controller pulses `start_i` after switching the bus into a high-speed mode. It then waits for `done_o`, which is accompanied by `err_o` and a code when tuning cannot complete, or by `skip_o` when the bus conditions do not call for tuning.

Top module: `dlt_phase_tuner`

## Requirements
- R1: A start while `hs_mode_i` or `fast_clk_i` is low performs no calibration and no test. The block answers with `done_o` and `skip_o` one cycle later, and `phase_o` keeps its value.
- R2: During calibration every configuration loaded into the line has select value 12 (one above the 11 taps), with `dl_enable_o` and `dl_sampler_o` both high.
- R3: Unit settings are tried in ascending order from 0. A reported length is accepted only when it is nonzero and below 2048. A rejected length moves on to the next unit, and the accepted unit stays on `dl_unit_o`.
- R4: When no length report arrives within `TIMEOUT_CYCLES` of a unit being loaded, that unit is abandoned and the next one is tried. The run is not aborted.
- R5: If no unit up to 127 yields an accepted length, the run ends with `err_o` and `err_code_o` = 1, `dl_unit_o` = 127 and `phase_o` unchanged.
- R6: The largest phase equals the bit index of the highest set bit of the accepted length. Exactly that many plus one tests are requested, for phases 0 upward.
- R7: Each test request is issued with `dl_enable_o` high and `dl_sampler_o` low, with the tested phase on `dl_sel_o`.
- R8: The chosen phase is the last phase of the longest passing run minus half that run's length, rounded down. Among equally long runs the earliest wins.
- R9: If no phase passes, the run ends with `err_o` and `err_code_o` = 2, and `phase_o` keeps its previous value.
- R10: `done_o`, `err_o` and `skip_o` are single-cycle pulses. `err_o` and `skip_o` occur only together with `done_o`. `err_code_o` is 0 after a run that succeeded or was skipped.
- R11: `phase_o` changes only in the cycle in which `done_o` is high.
- R12: After reset all outputs are low or zero.
- R13: A start while a run is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a tuning run (taken only when idle) |
| hs_mode_i | input | 1 | Bus is in one of the two highest-speed modes |
| fast_clk_i | input | 1 | Card clock is above 50 MHz |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | Run finished (pulse) |
| err_o | output | 1 | Run failed (pulse, with done) |
| err_code_o | output | 2 | 0 none, 1 calibration failed, 2 no passing phase |
| skip_o | output | 1 | Tuning was not needed (pulse, with done) |
| phase_o | output | 4 | Chosen sampling phase, held |
| dl_enable_o | output | 1 | Delay line enable |
| dl_sampler_o | output | 1 | Delay line length sampler enable |
| dl_unit_o | output | 7 | Unit delay setting |
| dl_sel_o | output | 4 | Phase (tap) select |
| dl_cfg_load_o | output | 1 | Configuration load strobe |
| dl_len_valid_i | input | 1 | Measured length is valid |
| dl_len_i | input | 12 | Measured line length |
| test_req_o | output | 1 | Request one tuning test (pulse) |
| test_resp_i | input | 1 | Test result is valid (pulse) |
| test_pass_i | input | 1 | Test passed, qualified by test_resp_i |

## Verification
Several rules are checked on every cycle by properties: the calibration configuration (select 12 with both enables), the sampler being low at each test request, the pulse shape of the completion outputs, an error always carrying a nonzero code, and the phase output changing only alongside completion. The choice of phase is covered only by scenarios, because it depends on the whole sequence of test outcomes. The same holds for the tie rule, the sweep limit taken from the measured length, skipping rejected or silent units, and both failure endings. Each of these is driven by a delay-line and test-port model whose pass patterns and length responses are chosen so that a wrong run tracker, a wrong sweep bound or a wrong acceptance window each yield a different phase, unit or request count.

// File: rtl/dlt_pkg.sv
package dlt_pkg;

    localparam int TAPS    = 11;
    localparam int UNIT_W  = 7;
    localparam int LEN_W   = 12;
    localparam int SEL_W   = $clog2(TAPS + 2);
    localparam int RUN_W   = $clog2(TAPS + 1);
    localparam int ERR_W   = 2;

    localparam logic [SEL_W-1:0]  CAL_SEL  = SEL_W'(TAPS + 1);
    localparam logic [UNIT_W-1:0] UNIT_MAX = {UNIT_W{1'b1}};

    typedef enum logic [ERR_W-1:0] {
        ERR_NONE = 2'd0,
        ERR_CAL  = 2'd1,
        ERR_NOPT = 2'd2
    } err_code_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CAL_CFG,
        S_CAL_WAIT,
        S_SW_CFG,
        S_SW_REQ,
        S_SW_WAIT,
        S_FIN,
        S_FIN_LOAD
    } state_t;

    typedef struct packed {
        logic              en;
        logic              samp;
        logic [SEL_W-1:0]  sel;
        logic [UNIT_W-1:0] unit;
    } dl_cfg_t;

    // Bit index of the highest set bit; zero for a zero input.
    function automatic logic [SEL_W-1:0] top_bit(input logic [LEN_W-1:0] v);
        logic [SEL_W-1:0] r;
        r = '0;
        for (int i = 0; i < LEN_W; i++) begin
            if (v[i]) r = SEL_W'(i);
        end
        return r;
    endfunction

    // A measured length fits when nonzero and below 2**TAPS.
    function automatic logic len_fits(input logic [LEN_W-1:0] v);
        return (v != '0) && ((v >> TAPS) == '0);
    endfunction

endpackage

// File: rtl/dlt_timer.sv
module dlt_timer #(
    parameter int LIMIT = 50000
) (
    input  logic clk,
    input  logic rst,
    input  logic clr_i,
    input  logic run_i,
    output logic expired_o
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt;

    assign expired_o = (cnt == CW'(LIMIT - 1));

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            cnt <= '0;
        end else if (run_i && !expired_o) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/dlt_run_tracker.sv
module dlt_run_tracker
    import dlt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_i,
    input  logic             upd_i,
    input  logic             pass_i,
    input  logic [SEL_W-1:0] idx_i,
    output logic [RUN_W-1:0] best_len_o,
    output logic [SEL_W-1:0] centre_o
);
    logic [RUN_W-1:0] cur_len;
    logic [RUN_W-1:0] best_len;
    logic [SEL_W-1:0] best_end;
    logic [RUN_W-1:0] cur_next;

    assign cur_next   = cur_len + 1'b1;
    assign best_len_o = best_len;
    assign centre_o   = best_end - SEL_W'(best_len >> 1);

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            cur_len  <= '0;
            best_len <= '0;
            best_end <= '0;
        end else if (upd_i) begin
            if (pass_i) begin
                cur_len <= cur_next;
                if (cur_next > best_len) begin
                    best_len <= cur_next;
                    best_end <= idx_i;
                end
            end else begin
                cur_len <= '0;
            end
        end
    end
endmodule

// File: rtl/dlt_sequencer.sv
module dlt_sequencer
    import dlt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             hs_mode_i,
    input  logic             fast_clk_i,
    input  logic             len_valid_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic             test_resp_i,
    input  logic             test_pass_i,
    input  logic             tmr_exp_i,
    input  logic [RUN_W-1:0] best_len_i,
    input  logic [SEL_W-1:0] centre_i,
    output logic             tmr_clr_o,
    output logic             tmr_run_o,
    output logic             trk_clr_o,
    output logic             trk_upd_o,
    output logic             trk_pass_o,
    output logic [SEL_W-1:0] trk_idx_o,
    output dl_cfg_t          cfg_o,
    output logic             cfg_load_o,
    output logic             test_req_o,
    output logic             busy_o,
    output logic             done_o,
    output logic             err_o,
    output err_code_t        err_code_o,
    output logic             skip_o,
    output logic [SEL_W-1:0] phase_o,
    output logic             cal_wait_o
);
    state_t            st;
    logic [UNIT_W-1:0] unit_q;
    logic [SEL_W-1:0]  ph_q;
    logic [SEL_W-1:0]  ph_max;
    logic              len_ok;

    assign len_ok     = len_valid_i && len_fits(len_i);
    assign tmr_clr_o  = (st == S_CAL_CFG);
    assign tmr_run_o  = (st == S_CAL_WAIT);
    assign trk_clr_o  = (st == S_IDLE) && start_i;
    assign trk_upd_o  = (st == S_SW_WAIT) && test_resp_i;
    assign trk_pass_o = test_pass_i;
    assign trk_idx_o  = ph_q;
    assign busy_o     = (st != S_IDLE);
    assign cal_wait_o = (st == S_CAL_WAIT);

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= S_IDLE;
            unit_q     <= '0;
            ph_q       <= '0;
            ph_max     <= '0;
            cfg_o      <= '0;
            cfg_load_o <= 1'b0;
            test_req_o <= 1'b0;
            done_o     <= 1'b0;
            err_o      <= 1'b0;
            err_code_o <= ERR_NONE;
            skip_o     <= 1'b0;
            phase_o    <= '0;
        end else begin
            done_o     <= 1'b0;
            err_o      <= 1'b0;
            skip_o     <= 1'b0;
            cfg_load_o <= 1'b0;
            test_req_o <= 1'b0;
            case (st)
                S_IDLE: begin
                    if (start_i) begin
                        err_code_o <= ERR_NONE;
                        if (hs_mode_i && fast_clk_i) begin
                            unit_q <= '0;
                            st     <= S_CAL_CFG;
                        end else begin
                            done_o <= 1'b1;
                            skip_o <= 1'b1;
                        end
                    end
                end
                S_CAL_CFG: begin
                    cfg_o.en   <= 1'b1;
                    cfg_o.samp <= 1'b1;
                    cfg_o.sel  <= CAL_SEL;
                    cfg_o.unit <= unit_q;
                    cfg_load_o <= 1'b1;
                    st         <= S_CAL_WAIT;
                end
                S_CAL_WAIT: begin
                    if (len_ok) begin
                        ph_max <= top_bit(len_i);
                        ph_q   <= '0;
                        st     <= S_SW_CFG;
                    end else if (len_valid_i || tmr_exp_i) begin
                        if (unit_q == UNIT_MAX) begin
                            cfg_o.en   <= 1'b0;
                            cfg_o.samp <= 1'b0;
                            err_code_o <= ERR_CAL;
                            err_o      <= 1'b1;
                            done_o     <= 1'b1;
                            st         <= S_IDLE;
                        end else begin
                            unit_q <= unit_q + 1'b1;
                            st     <= S_CAL_CFG;
                        end
                    end
                end
                S_SW_CFG: begin
                    cfg_o.samp <= 1'b1;
                    cfg_o.sel  <= ph_q;
                    cfg_load_o <= 1'b1;
                    st         <= S_SW_REQ;
                end
                S_SW_REQ: begin
                    cfg_o.samp <= 1'b0;
                    test_req_o <= 1'b1;
                    st         <= S_SW_WAIT;
                end
                S_SW_WAIT: begin
                    if (test_resp_i) begin
                        if (ph_q == ph_max) begin
                            st <= S_FIN;
                        end else begin
                            ph_q <= ph_q + 1'b1;
                            st   <= S_SW_CFG;
                        end
                    end
                end
                S_FIN: begin
                    if (best_len_i == '0) begin
                        cfg_o.sel  <= phase_o;
                        err_code_o <= ERR_NOPT;
                        err_o      <= 1'b1;
                        done_o     <= 1'b1;
                        st         <= S_IDLE;
                    end else begin
                        cfg_o.samp <= 1'b1;
                        cfg_o.sel  <= centre_i;
                        cfg_load_o <= 1'b1;
                        st         <= S_FIN_LOAD;
                    end
                end
                S_FIN_LOAD: begin
                    cfg_o.samp <= 1'b0;
                    phase_o    <= cfg_o.sel;
                    done_o     <= 1'b1;
                    st         <= S_IDLE;
                end
                default: st <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/dlt_phase_tuner.sv
module dlt_phase_tuner
    import dlt_pkg::*;
#(
    parameter int TIMEOUT_CYCLES = 50000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              hs_mode_i,
    input  logic              fast_clk_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o,
    output logic [ERR_W-1:0]  err_code_o,
    output logic              skip_o,
    output logic [SEL_W-1:0]  phase_o,
    output logic              dl_enable_o,
    output logic              dl_sampler_o,
    output logic [UNIT_W-1:0] dl_unit_o,
    output logic [SEL_W-1:0]  dl_sel_o,
    output logic              dl_cfg_load_o,
    input  logic              dl_len_valid_i,
    input  logic [LEN_W-1:0]  dl_len_i,
    output logic              test_req_o,
    input  logic              test_resp_i,
    input  logic              test_pass_i
);
    logic             tmr_clr, tmr_run, tmr_exp;
    logic             trk_clr, trk_upd, trk_pass;
    logic [SEL_W-1:0] trk_idx, centre;
    logic [RUN_W-1:0] best_len;
    dl_cfg_t          cfg;
    err_code_t        code;
    logic             cal_wait;

    dlt_timer #(.LIMIT(TIMEOUT_CYCLES)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .clr_i     (tmr_clr),
        .run_i     (tmr_run),
        .expired_o (tmr_exp)
    );

    dlt_run_tracker u_track (
        .clk        (clk),
        .rst        (rst),
        .clr_i      (trk_clr),
        .upd_i      (trk_upd),
        .pass_i     (trk_pass),
        .idx_i      (trk_idx),
        .best_len_o (best_len),
        .centre_o   (centre)
    );

    dlt_sequencer u_seq (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .hs_mode_i   (hs_mode_i),
        .fast_clk_i  (fast_clk_i),
        .len_valid_i (dl_len_valid_i),
        .len_i       (dl_len_i),
        .test_resp_i (test_resp_i),
        .test_pass_i (test_pass_i),
        .tmr_exp_i   (tmr_exp),
        .best_len_i  (best_len),
        .centre_i    (centre),
        .tmr_clr_o   (tmr_clr),
        .tmr_run_o   (tmr_run),
        .trk_clr_o   (trk_clr),
        .trk_upd_o   (trk_upd),
        .trk_pass_o  (trk_pass),
        .trk_idx_o   (trk_idx),
        .cfg_o       (cfg),
        .cfg_load_o  (dl_cfg_load_o),
        .test_req_o  (test_req_o),
        .busy_o      (busy_o),
        .done_o      (done_o),
        .err_o       (err_o),
        .err_code_o  (code),
        .skip_o      (skip_o),
        .phase_o     (phase_o),
        .cal_wait_o  (cal_wait)
    );

    assign err_code_o   = code;
    assign dl_enable_o  = cfg.en;
    assign dl_sampler_o = cfg.samp;
    assign dl_unit_o    = cfg.unit;
    assign dl_sel_o     = cfg.sel;
endmodule

// File: rtl/dlt_phase_tuner_chk.sv
module dlt_phase_tuner_chk
    import dlt_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             done_o,
    input logic             err_o,
    input logic [ERR_W-1:0] err_code_o,
    input logic             skip_o,
    input logic [SEL_W-1:0] phase_o,
    input logic             dl_enable_o,
    input logic             dl_sampler_o,
    input logic [SEL_W-1:0] dl_sel_o,
    input logic             test_req_o,
    input logic             cal_wait
);
    p_cal_cfg_r2: assert property (@(posedge clk) disable iff (rst)
        cal_wait |-> (dl_sel_o == CAL_SEL) && dl_enable_o && dl_sampler_o);

    p_req_nosamp_r7: assert property (@(posedge clk) disable iff (rst)
        test_req_o |-> dl_enable_o && !dl_sampler_o && (dl_sel_o < SEL_W'(TAPS)));

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    p_err_with_done_r10: assert property (@(posedge clk) disable iff (rst)
        (err_o || skip_o) |-> done_o);

    p_err_code_r10: assert property (@(posedge clk) disable iff (rst)
        err_o |-> (err_code_o != '0));

    p_phase_hold_r11: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> $stable(phase_o));

    p_nopt_keep_r9: assert property (@(posedge clk) disable iff (rst)
        (err_o && err_code_o == ERR_NOPT) |-> $stable(phase_o));
endmodule

bind dlt_phase_tuner dlt_phase_tuner_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .done_o       (done_o),
    .err_o        (err_o),
    .err_code_o   (err_code_o),
    .skip_o       (skip_o),
    .phase_o      (phase_o),
    .dl_enable_o  (dl_enable_o),
    .dl_sampler_o (dl_sampler_o),
    .dl_sel_o     (dl_sel_o),
    .test_req_o   (test_req_o),
    .cal_wait     (cal_wait)
);

// File: tb/dlt_phase_tuner_test.sv
module dlt_phase_tuner_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic        hs_mode_i = 1'b0;
    logic        fast_clk_i = 1'b0;
    logic        busy_o, done_o, err_o, skip_o;
    logic [1:0]  err_code_o;
    logic [3:0]  phase_o;
    logic        dl_enable_o, dl_sampler_o, dl_cfg_load_o;
    logic [6:0]  dl_unit_o;
    logic [3:0]  dl_sel_o;
    logic        dl_len_valid_i = 1'b0;
    logic [11:0] dl_len_i = '0;
    logic        test_req_o;
    logic        test_resp_i = 1'b0;
    logic        test_pass_i = 1'b0;

    always #10 clk = ~clk;

    dlt_phase_tuner #(.TIMEOUT_CYCLES(64)) uut (
        .clk            (clk),
        .rst            (rst),
        .start_i        (start_i),
        .hs_mode_i      (hs_mode_i),
        .fast_clk_i     (fast_clk_i),
        .busy_o         (busy_o),
        .done_o         (done_o),
        .err_o          (err_o),
        .err_code_o     (err_code_o),
        .skip_o         (skip_o),
        .phase_o        (phase_o),
        .dl_enable_o    (dl_enable_o),
        .dl_sampler_o   (dl_sampler_o),
        .dl_unit_o      (dl_unit_o),
        .dl_sel_o       (dl_sel_o),
        .dl_cfg_load_o  (dl_cfg_load_o),
        .dl_len_valid_i (dl_len_valid_i),
        .dl_len_i       (dl_len_i),
        .test_req_o     (test_req_o),
        .test_resp_i    (test_resp_i),
        .test_pass_i    (test_pass_i)
    );

    typedef struct packed {
        logic        hs;
        logic        fast;
        logic        tmo;
        logic [7:0]  good;
        logic [11:0] len;
        logic [10:0] mask;
        logic [1:0]  code;
        logic [3:0]  phase;
        logic [6:0]  unit;
        logic [4:0]  nreq;
        logic        skip;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 1'b1, 1'b0, 8'd3,   12'h3FF, 11'h078, 2'd0, 4'd4, 7'd3,   5'd10, 1'b0},
        '{1'b1, 1'b1, 1'b1, 8'd2,   12'h7FF, 11'h4E3, 2'd0, 4'd6, 7'd2,   5'd11, 1'b0},
        '{1'b1, 1'b1, 1'b0, 8'd5,   12'h001, 11'h001, 2'd0, 4'd0, 7'd5,   5'd1,  1'b0},
        '{1'b1, 1'b1, 1'b0, 8'd0,   12'h0F0, 11'h706, 2'd0, 4'd1, 7'd0,   5'd8,  1'b0},
        '{1'b1, 1'b1, 1'b0, 8'd1,   12'h1FF, 11'h0CC, 2'd0, 4'd2, 7'd1,   5'd9,  1'b0},
        '{1'b1, 1'b1, 1'b0, 8'd0,   12'h3FF, 11'h7FF, 2'd0, 4'd4, 7'd0,   5'd10, 1'b0},
        '{1'b1, 1'b1, 1'b0, 8'd0,   12'h3FF, 11'h000, 2'd2, 4'd4, 7'd0,   5'd10, 1'b0},
        '{1'b0, 1'b1, 1'b0, 8'd0,   12'h3FF, 11'h7FF, 2'd0, 4'd4, 7'd0,   5'd0,  1'b1},
        '{1'b1, 1'b0, 1'b0, 8'd0,   12'h3FF, 11'h7FF, 2'd0, 4'd4, 7'd0,   5'd0,  1'b1},
        '{1'b1, 1'b1, 1'b0, 8'd200, 12'h3FF, 11'h7FF, 2'd1, 4'd4, 7'd127, 5'd0,  1'b0},
        '{1'b1, 1'b1, 1'b1, 8'd200, 12'h3FF, 11'h7FF, 2'd1, 4'd4, 7'd127, 5'd0,  1'b0},
        '{1'b1, 1'b1, 1'b0, 8'd0,   12'h3FF, 11'h200, 2'd0, 4'd9, 7'd0,   5'd10, 1'b0}
    };

    int errors = 0;
    int checks = 0;

    // scenario knobs for the models
    logic        m_tmo = 1'b0;
    logic [7:0]  m_good = '0;
    logic [11:0] m_len = '0;
    logic [10:0] m_mask = '0;
    int          nreq = 0;
    int          ndone = 0;
    logic        bad_cal = 1'b0;
    logic        bad_req = 1'b0;
    logic        bad_hold = 1'b0;
    logic [3:0]  prev_phase = '0;

    // delay-line model: reports a length some cycles after a sampled load
    int   lat = 0;
    logic pend = 1'b0;
    always @(negedge clk) begin
        if (dl_cfg_load_o) begin
            dl_len_valid_i = 1'b0;
            pend = 1'b0;
            if (dl_sel_o == 4'd12 && !(dl_enable_o && dl_sampler_o)) bad_cal = 1'b1;
            if (dl_sampler_o && !({1'b0, dl_unit_o} < m_good && m_tmo)) begin
                pend = 1'b1;
                lat = 3;
            end
        end else if (pend) begin
            if (lat > 1) begin
                lat = lat - 1;
            end else begin
                pend = 1'b0;
                dl_len_valid_i = 1'b1;
                if ({1'b0, dl_unit_o} < m_good)
                    dl_len_i = dl_unit_o[0] ? 12'h000 : 12'h800;
                else
                    dl_len_i = m_len;
            end
        end
    end

    // tuning-test model: answers two cycles after each request
    int   rq_dly = 0;
    logic rq_pass = 1'b0;
    always @(negedge clk) begin
        test_resp_i = 1'b0;
        if (rq_dly != 0) begin
            rq_dly = rq_dly - 1;
            if (rq_dly == 0) begin
                test_resp_i = 1'b1;
                test_pass_i = rq_pass;
            end
        end
        if (test_req_o) begin
            if (dl_sampler_o || !dl_enable_o) bad_req = 1'b1;
            rq_dly = 2;
            rq_pass = (dl_sel_o < 4'd11) ? m_mask[dl_sel_o] : 1'b0;
            nreq = nreq + 1;
        end
        if (done_o) ndone = ndone + 1;
        if (!rst && !done_o && phase_o != prev_phase) bad_hold = 1'b1;
        prev_phase = phase_o;
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // start a run and wait for done; returns 0 when the watchdog expires
    task automatic run_once(output bit ok);
        int wd;
        ok = 1'b1;
        nreq = 0;
        @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        wd = 0;
        while (!done_o) begin
            @(negedge clk);
            wd++;
            if (wd > 40000) begin
                ok = 1'b0;
                break;
            end
        end
    endtask

    initial begin
        bit ok;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12: reset state
        chk("R12 outputs idle", {busy_o, done_o, err_o, skip_o, dl_enable_o,
            dl_sampler_o, dl_cfg_load_o, test_req_o}, 0);
        chk("R12 phase", phase_o, 0);
        chk("R12 code/unit/sel", {err_code_o, dl_unit_o, dl_sel_o}, 0);

        for (int i = 0; i < NV; i++) begin
            hs_mode_i  = VEC[i].hs;
            fast_clk_i = VEC[i].fast;
            m_tmo  = VEC[i].tmo;
            m_good = VEC[i].good;
            m_len  = VEC[i].len;
            m_mask = VEC[i].mask;
            run_once(ok);
            if (!ok) begin
                chk("watchdog expired", 1, 0);
                break;
            end
            chk("R1 skip flag", skip_o, VEC[i].skip);
            chk("R5/R9 err pulse", err_o, VEC[i].code != 0);
            chk("R5/R9 err code", err_code_o, VEC[i].code);
            chk("R8 phase", phase_o, VEC[i].phase);
            chk("R3/R4 unit", dl_unit_o, VEC[i].unit);
            chk("R6 test count", nreq, VEC[i].nreq);
            @(negedge clk);
            chk("R10 single-cycle done", {done_o, err_o, skip_o}, 0);
        end

        chk("R2 calibration loads", bad_cal, 0);
        chk("R7 sampler low at request", bad_req, 0);
        chk("R11 phase held between runs", bad_hold, 0);

        // R13: second start during a run is ignored
        hs_mode_i = 1'b1; fast_clk_i = 1'b1;
        m_tmo = 1'b0; m_good = 8'd3; m_len = 12'h3FF; m_mask = 11'h078;
        nreq = 0;
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        repeat (20) @(negedge clk);
        start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        ndone = 0;
        repeat (600) @(negedge clk);
        chk("R13 one completion", ndone, 1);
        chk("R13 test count", nreq, 10);
        chk("R13 phase", phase_o, 4);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule